// File: doc/BRIEF.md
# Rendering Coprocessor Control Front End

This block is the host-facing control unit of a small rendering coprocessor. A host issues 32-bit register writes and reads on a simple strobe bus. The block holds the engine's control and status word, a sticky error word, a pair of address-window limits, a plane mask, a raster-operation byte, a diagnostics word, an overflow counter, a start value for general register zero and a fixed identification word. It also holds a 128-entry general register file. Rendering instructions and the pixel datapath sit outside this block and are not part of it.

The register file can be reached in two ways. The direct window writes an entry at once, but only while the engine is stopped. The queued window pushes an index and data pair into a four-entry queue, which commits one entry per cycle to the register file while the engine runs. The whole map appears a second time, 0x1000 bytes higher, as a user view in which the two window-limit registers cannot be written. Memory-instruction addresses arrive on a separate port and are checked against the window limits. Faults are collected in the error word and, when enabled, drive an interrupt line.

Top module: `renderCtrlUnit`

## Requirements
- R1: After reset, control reads 0x00008000, error reads 0, the lower limit reads 0, the upper limit reads 0xFFFFFFFF, the ID word at 0x28 reads {16'h0, revision, architecture} (0x0000032A by default) and irq is low.
- R2: Aligned writes to control 0x00, lower limit 0x08, upper limit 0x0C, plane mask 0x10, raster op 0x14, overflow counter 0x18, diagnostics 0x1C and R0-start 0x2C read back. The raster op keeps bits 7:0 only. Control keeps bits 5:0, 7, 12, 13 and 14. Read data appears on the clock edge that samples the read strobe.
- R3: A write to 0x100+4n sets general register n only while control bit 14 (run) is 0; when the bit is 1 the write has no effect. Reads of 0x100+4n return register n at any time.
- R4: A write to 0x300+4n queues the pair (n, data). While run is 1, the queue commits one entry per cycle, oldest first, into the register file, and each commit sets control bit 13.
- R5: Error bits 5:0 are sticky. A host write to the error word at 0x04 loads them from data bits 5:0, so writing zero clears them all. Error bit 7 reads as the interrupt-pending state.
- R6: irq is high exactly when control bit 7 is 1 and some error bit i (i in 0..5) is set while control bit i is also 1.
- R7: Control bit 15 reads 1 exactly when the four-entry queue is empty.
- R8: A queued write that arrives while the queue holds four entries is dropped. It increments the overflow counter by one and sets error bit 5.
- R9: In the user view (byte address + 0x1000), the registers read and write as in the base view, except that writes to 0x1008 and 0x100C have no effect.
- R10: When control bit 12 is 1, a memory request whose address is below the lower limit or above the upper limit sets error bit 1. Addresses equal to either limit, and every address while bit 12 is 0, leave the error word unchanged.
- R11: A write whose address bits 1:0 are not zero changes no register and sets error bit 4.
- R12: An aligned write to an unmapped offset changes nothing and sets error bit 3. Reads of unmapped offsets return 0. Writes to the ID word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 13 | Host byte address; bit 12 selects the user view |
| busWrData | input | 32 | Host write data |
| busRdData | output | 32 | Registered host read data |
| memReqValid | input | 1 | Memory-instruction address valid |
| memReqAddr | input | 32 | Memory-instruction address to check against the limits |
| irq | output | 1 | Error interrupt |

## Verification
The bench goes after the queue edges. It fills the queue to four entries and sends a fifth. A design with an off-by-one full test would accept that fifth entry, or drop the fourth, and the overflow count and the committed registers would then be wrong. Two queued writes to the same register check commit order: a design that drained newest-first would leave the older value. The window-limit check is probed at both limit values and one step beyond each, where a comparison with the wrong strictness sets or misses the error. The bench also tries a direct write while running, limit writes through the user view, and misaligned and unmapped writes. Each of these must leave the targeted register unchanged, so any path that leaks the write shows up on readback.

// File: rtl/renderCtrlPkg.sv
package renderCtrlPkg;

  localparam int unsigned OFS_CTRL   = 'h000;
  localparam int unsigned OFS_ERR    = 'h004;
  localparam int unsigned OFS_LOWER  = 'h008;
  localparam int unsigned OFS_UPPER  = 'h00C;
  localparam int unsigned OFS_MASK   = 'h010;
  localparam int unsigned OFS_ROP    = 'h014;
  localparam int unsigned OFS_OVF    = 'h018;
  localparam int unsigned OFS_DIAG   = 'h01C;
  localparam int unsigned OFS_ID     = 'h028;
  localparam int unsigned OFS_R0INIT = 'h02C;
  localparam int unsigned WIN_DIRECT = 'h100;
  localparam int unsigned WIN_QUEUE  = 'h300;

  localparam int unsigned BIT_INT_EN  = 7;
  localparam int unsigned BIT_BOUNDCK = 12;
  localparam int unsigned BIT_WROCC   = 13;
  localparam int unsigned BIT_RUN     = 14;
  localparam int unsigned BIT_EMPTY   = 15;

  localparam int unsigned ERR_BOUND    = 1;
  localparam int unsigned ERR_BADREG   = 3;
  localparam int unsigned ERR_MISALIGN = 4;
  localparam int unsigned ERR_QOVF     = 5;
  localparam int unsigned NUM_CAUSES   = 6;

  localparam logic [31:0] CTRL_WR_MASK = 32'h0000_70BF;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_ERR, RD_LOWER, RD_UPPER, RD_MASK, RD_ROP,
    RD_OVF, RD_DIAG, RD_ID, RD_R0INIT, RD_REG
  } rdSel_t;

  typedef struct packed {
    logic rdReq;
    logic wrCtrl;
    logic wrErr;
    logic wrLower;
    logic wrUpper;
    logic wrMask;
    logic wrRop;
    logic wrOvf;
    logic wrDiag;
    logic wrR0Init;
    logic wrDirect;
    logic pushQueue;
    logic dropQueue;
    logic errMisalign;
    logic errBadReg;
  } ctrlStrobe_t;

endpackage

// File: rtl/renderCtrlDecode.sv
module renderCtrlDecode
  import renderCtrlPkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              runBit,
  input  logic              queueFull,
  output ctrlStrobe_t       stb,
  output rdSel_t            rdSel,
  output logic [IDX_W-1:0]  regIdx
);

  localparam int OFF_W   = ADDR_W - 1;
  localparam int WIN_LEN = NUM_REGS * 4;

  logic [OFF_W-1:0] offset;
  logic             userView;
  logic             aligned;
  logic             directHit;
  logic             queueHit;
  logic [OFF_W-1:0] directRel;
  logic [OFF_W-1:0] queueRel;

  assign offset   = busAddr[OFF_W-1:0];
  assign userView = busAddr[ADDR_W-1];
  assign aligned  = (busAddr[1:0] == 2'b00);

  assign directHit = (offset >= OFF_W'(WIN_DIRECT)) && (offset < OFF_W'(WIN_DIRECT + WIN_LEN));
  assign queueHit  = (offset >= OFF_W'(WIN_QUEUE))  && (offset < OFF_W'(WIN_QUEUE + WIN_LEN));
  assign directRel = offset - OFF_W'(WIN_DIRECT);
  assign queueRel  = offset - OFF_W'(WIN_QUEUE);
  assign regIdx    = queueHit ? IDX_W'(queueRel >> 2) : IDX_W'(directRel >> 2);

  always_comb begin
    stb = '0;
    if (busWrEn) begin
      if (!aligned) begin
        stb.errMisalign = 1'b1;
      end else if (offset == OFF_W'(OFS_CTRL)) begin
        stb.wrCtrl = 1'b1;
      end else if (offset == OFF_W'(OFS_ERR)) begin
        stb.wrErr = 1'b1;
      end else if (offset == OFF_W'(OFS_LOWER)) begin
        stb.wrLower = !userView;
      end else if (offset == OFF_W'(OFS_UPPER)) begin
        stb.wrUpper = !userView;
      end else if (offset == OFF_W'(OFS_MASK)) begin
        stb.wrMask = 1'b1;
      end else if (offset == OFF_W'(OFS_ROP)) begin
        stb.wrRop = 1'b1;
      end else if (offset == OFF_W'(OFS_OVF)) begin
        stb.wrOvf = 1'b1;
      end else if (offset == OFF_W'(OFS_DIAG)) begin
        stb.wrDiag = 1'b1;
      end else if (offset == OFF_W'(OFS_R0INIT)) begin
        stb.wrR0Init = 1'b1;
      end else if (offset == OFF_W'(OFS_ID)) begin
        stb.wrCtrl = 1'b0;
      end else if (directHit) begin
        stb.wrDirect = !runBit;
      end else if (queueHit) begin
        stb.pushQueue = !queueFull;
        stb.dropQueue = queueFull;
      end else begin
        stb.errBadReg = 1'b1;
      end
    end
    stb.rdReq = busRdEn;
  end

  always_comb begin
    rdSel = RD_NONE;
    if (aligned) begin
      if      (offset == OFF_W'(OFS_CTRL))   rdSel = RD_CTRL;
      else if (offset == OFF_W'(OFS_ERR))    rdSel = RD_ERR;
      else if (offset == OFF_W'(OFS_LOWER))  rdSel = RD_LOWER;
      else if (offset == OFF_W'(OFS_UPPER))  rdSel = RD_UPPER;
      else if (offset == OFF_W'(OFS_MASK))   rdSel = RD_MASK;
      else if (offset == OFF_W'(OFS_ROP))    rdSel = RD_ROP;
      else if (offset == OFF_W'(OFS_OVF))    rdSel = RD_OVF;
      else if (offset == OFF_W'(OFS_DIAG))   rdSel = RD_DIAG;
      else if (offset == OFF_W'(OFS_ID))     rdSel = RD_ID;
      else if (offset == OFF_W'(OFS_R0INIT)) rdSel = RD_R0INIT;
      else if (directHit)                    rdSel = RD_REG;
    end
  end

  // R9: the user view never produces a limit-register write strobe
  assert_user_bounds_ro_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && userView) |-> !(stb.wrLower || stb.wrUpper));

  // R2: a single host access triggers at most one write action
  assert_one_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCtrl, stb.wrErr, stb.wrLower, stb.wrUpper, stb.wrMask, stb.wrRop,
              stb.wrOvf, stb.wrDiag, stb.wrR0Init, stb.wrDirect, stb.pushQueue,
              stb.dropQueue, stb.errMisalign, stb.errBadReg}));

endmodule

// File: rtl/renderCtrlData.sv
module renderCtrlData
  import renderCtrlPkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          NUM_REGS    = 128,
  parameter int          QUEUE_DEPTH = 4,
  parameter int          OVF_W       = 16,
  parameter logic [7:0]  ARCH_CODE   = 8'h2A,
  parameter logic [7:0]  CHIP_REV    = 8'h03,
  parameter int          IDX_W       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  rdSel_t            rdSel,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              memReqValid,
  input  logic [DATA_W-1:0] memReqAddr,
  output logic              runBit,
  output logic              queueFull,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  logic [DATA_W-1:0] ctrlReg;
  logic [NUM_CAUSES-1:0] errFlags;
  logic [DATA_W-1:0] lowerLim;
  logic [DATA_W-1:0] upperLim;
  logic [DATA_W-1:0] planeMask;
  logic [7:0]        ropByte;
  logic [OVF_W-1:0]  ovfCount;
  logic [DATA_W-1:0] diagReg;
  logic [DATA_W-1:0] r0Init;
  logic [DATA_W-1:0] regFile [NUM_REGS];

  logic [IDX_W-1:0]  qIdx  [QUEUE_DEPTH];
  logic [DATA_W-1:0] qData [QUEUE_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  qCount;
  logic              qEmpty;
  logic              popValid;
  logic              boundErr;
  logic [NUM_CAUSES-1:0] hwSet;

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign runBit    = ctrlReg[BIT_RUN];
  assign qEmpty    = (qCount == '0);
  assign queueFull = (qCount == CNT_W'(QUEUE_DEPTH));
  assign popValid  = runBit && !qEmpty;

  // limit check on memory-instruction addresses
  assign boundErr = memReqValid && ctrlReg[BIT_BOUNDCK] &&
                    ((memReqAddr < lowerLim) || (memReqAddr > upperLim));

  always_comb begin
    hwSet = '0;
    hwSet[ERR_BOUND]    = boundErr;
    hwSet[ERR_BADREG]   = stb.errBadReg;
    hwSet[ERR_MISALIGN] = stb.errMisalign;
    hwSet[ERR_QOVF]     = stb.dropQueue;
  end

  assign irq = ctrlReg[BIT_INT_EN] && |(errFlags & ctrlReg[NUM_CAUSES-1:0]);

  // control, limits and plain storage registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      errFlags  <= '0;
      lowerLim  <= '0;
      upperLim  <= '1;
      planeMask <= '0;
      ropByte   <= '0;
      ovfCount  <= '0;
      diagReg   <= '0;
      r0Init    <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= wrData & CTRL_WR_MASK;
      if (popValid)   ctrlReg[BIT_WROCC] <= 1'b1;
      errFlags <= (stb.wrErr ? wrData[NUM_CAUSES-1:0] : errFlags) | hwSet;
      if (stb.wrLower)  lowerLim  <= wrData;
      if (stb.wrUpper)  upperLim  <= wrData;
      if (stb.wrMask)   planeMask <= wrData;
      if (stb.wrRop)    ropByte   <= wrData[7:0];
      if (stb.wrDiag)   diagReg   <= wrData;
      if (stb.wrR0Init) r0Init    <= wrData;
      if (stb.wrOvf)          ovfCount <= wrData[OVF_W-1:0];
      else if (stb.dropQueue) ovfCount <= ovfCount + 1'b1;
    end
  end

  // queued-write FIFO
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (stb.pushQueue) wrPtr <= ptrNext(wrPtr);
      if (popValid)      rdPtr <= ptrNext(rdPtr);
      qCount <= qCount + CNT_W'(stb.pushQueue) - CNT_W'(popValid);
    end
  end

  generate
    for (genvar e = 0; e < QUEUE_DEPTH; e++) begin : gQueueSlot
      always_ff @(posedge clk) begin
        if (stb.pushQueue && (wrPtr == PTR_W'(e))) begin
          qIdx[e]  <= regIdx;
          qData[e] <= wrData;
        end
      end
    end
  endgenerate

  // general register file: direct port when stopped, queue commits when running
  always_ff @(posedge clk) begin
    if (stb.wrDirect)   regFile[regIdx]     <= wrData;
    else if (popValid)  regFile[qIdx[rdPtr]] <= qData[rdPtr];
  end

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.rdReq) begin
      unique case (rdSel)
        RD_CTRL:   rdData <= ctrlReg | (DATA_W'(qEmpty) << BIT_EMPTY);
        RD_ERR:    rdData <= DATA_W'({irq, 1'b0, errFlags});
        RD_LOWER:  rdData <= lowerLim;
        RD_UPPER:  rdData <= upperLim;
        RD_MASK:   rdData <= planeMask;
        RD_ROP:    rdData <= DATA_W'(ropByte);
        RD_OVF:    rdData <= DATA_W'(ovfCount);
        RD_DIAG:   rdData <= diagReg;
        RD_ID:     rdData <= DATA_W'({CHIP_REV, ARCH_CODE});
        RD_R0INIT: rdData <= r0Init;
        RD_REG:    rdData <= regFile[regIdx];
        default:   rdData <= '0;
      endcase
    end
  end

  assert_queue_bounded_R7: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= CNT_W'(QUEUE_DEPTH));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrErr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  assert_drop_counts_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.dropQueue |=> (ovfCount == $past(ovfCount) + 1'b1));

  assert_misalign_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.errMisalign |=> errFlags[ERR_MISALIGN]);

  assert_commit_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    popValid |=> ctrlReg[BIT_WROCC]);

endmodule

// File: rtl/renderCtrlUnit.sv
module renderCtrlUnit
  import renderCtrlPkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         DATA_W      = 32,
  parameter int         NUM_REGS    = 128,
  parameter int         QUEUE_DEPTH = 4,
  parameter int         OVF_W       = 16,
  parameter logic [7:0] ARCH_CODE   = 8'h2A,
  parameter logic [7:0] CHIP_REV    = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              memReqValid,
  input  logic [DATA_W-1:0] memReqAddr,
  output logic              irq
);

  localparam int IDX_W = $clog2(NUM_REGS);

  ctrlStrobe_t      stb;
  rdSel_t           rdSel;
  logic [IDX_W-1:0] regIdx;
  logic             runBit;
  logic             queueFull;

  renderCtrlDecode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
  ) i_decode (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .runBit(runBit), .queueFull(queueFull),
    .stb(stb), .rdSel(rdSel), .regIdx(regIdx)
  );

  renderCtrlData #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .QUEUE_DEPTH(QUEUE_DEPTH),
    .OVF_W(OVF_W), .ARCH_CODE(ARCH_CODE), .CHIP_REV(CHIP_REV), .IDX_W(IDX_W)
  ) i_data (
    .clk(clk), .rstN(rstN),
    .stb(stb), .rdSel(rdSel), .regIdx(regIdx), .wrData(busWrData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .runBit(runBit), .queueFull(queueFull),
    .rdData(busRdData), .irq(irq)
  );

endmodule

// File: tb/test_renderCtrlUnit.sv
`timescale 1ns/1ps
module test_renderCtrlUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [12:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        memReqValid = 1'b0;
  logic [31:0] memReqAddr = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  renderCtrlUnit i_renderCtrlUnit (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic expectReg(input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic memProbe(input logic [31:0] a);
    @(negedge clk);
    memReqValid = 1'b1; memReqAddr = a;
    @(negedge clk);
    memReqValid = 1'b0;
  endtask

  task automatic testReset();
    expectReg("R1 ctrl", 13'h000, 32'h0000_8000);
    expectReg("R1 err", 13'h004, 32'h0);
    expectReg("R1 lower", 13'h008, 32'h0);
    expectReg("R1 upper", 13'h00C, 32'hFFFF_FFFF);
    expectReg("R1 id", 13'h028, 32'h0000_032A);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testRegMap();
    busWrite(13'h010, 32'hA5A5_5A5A);
    expectReg("R2 mask", 13'h010, 32'hA5A5_5A5A);
    busWrite(13'h014, 32'h0000_1234);
    expectReg("R2 rop", 13'h014, 32'h0000_0034);
    busWrite(13'h01C, 32'h0BAD_F00D);
    expectReg("R2 diag", 13'h01C, 32'h0BAD_F00D);
    busWrite(13'h02C, 32'h1357_9BDF);
    expectReg("R2 r0init", 13'h02C, 32'h1357_9BDF);
    busWrite(13'h018, 32'h0000_0007);
    expectReg("R2 ovf", 13'h018, 32'h0000_0007);
    busWrite(13'h018, 32'h0);
    busWrite(13'h000, 32'hFFFF_FFFF);
    expectReg("R2 ctrl mask", 13'h000, 32'h0000_F0BF);
    busWrite(13'h000, 32'h0);
    busWrite(13'h004, 32'h0);
  endtask

  task automatic testDirect();
    busWrite(13'h114, 32'hDEAD_0005);
    expectReg("R3 direct r5", 13'h114, 32'hDEAD_0005);
    busWrite(13'h2FC, 32'h7F7F_7F7F);
    expectReg("R3 direct r127", 13'h2FC, 32'h7F7F_7F7F);
    busWrite(13'h000, 32'h0000_4000);
    busWrite(13'h114, 32'h0000_1111);
    expectReg("R3 blocked while running", 13'h114, 32'hDEAD_0005);
    busWrite(13'h000, 32'h0);
  endtask

  task automatic testQueue();
    busWrite(13'h138, 32'h0E0E_0E0E);   // R14 preset directly
    busWrite(13'h328, 32'hAAAA_000A);   // R10
    busWrite(13'h32C, 32'hBBBB_000B);   // R11
    busWrite(13'h330, 32'hCCCC_0001);   // R12 older
    busWrite(13'h330, 32'hCCCC_0002);   // R12 newer
    expectReg("R7 full not empty", 13'h000, 32'h0);
    busWrite(13'h338, 32'h1414_1414);   // dropped
    expectReg("R8 ovf count", 13'h018, 32'h1);
    expectReg("R8 err bit5", 13'h004, 32'h20);
    busWrite(13'h004, 32'h0);
    expectReg("R5 clear by zero", 13'h004, 32'h0);
    busWrite(13'h000, 32'h0000_4000);
    repeat (6) @(negedge clk);
    expectReg("R4 R7 ctrl after drain", 13'h000, 32'h0000_E000);
    expectReg("R4 r10", 13'h128, 32'hAAAA_000A);
    expectReg("R4 r11", 13'h12C, 32'hBBBB_000B);
    expectReg("R4 order r12", 13'h130, 32'hCCCC_0002);
    expectReg("R8 dropped r14", 13'h138, 32'h0E0E_0E0E);
    busWrite(13'h000, 32'h0);
  endtask

  task automatic testBound();
    busWrite(13'h008, 32'h0000_1000);
    busWrite(13'h00C, 32'h0000_1FFF);
    memProbe(32'h0000_0500);
    expectReg("R10 disabled", 13'h004, 32'h0);
    busWrite(13'h000, 32'h0000_1000);
    memProbe(32'h0000_1800);
    memProbe(32'h0000_1000);
    memProbe(32'h0000_1FFF);
    expectReg("R10 inside and edges", 13'h004, 32'h0);
    memProbe(32'h0000_2000);
    expectReg("R10 above upper", 13'h004, 32'h2);
    busWrite(13'h004, 32'h0);
    memProbe(32'h0000_0FFF);
    expectReg("R10 below lower", 13'h004, 32'h2);
    busWrite(13'h004, 32'h0);
  endtask

  task automatic testIrq();
    busWrite(13'h000, 32'h0000_1002);
    memProbe(32'h0000_3000);
    check("R6 no irq without enable", {31'b0, irq}, 32'h0);
    busWrite(13'h000, 32'h0000_1082);
    @(negedge clk);
    check("R6 irq raised", {31'b0, irq}, 32'h1);
    expectReg("R5 pending bit7", 13'h004, 32'h82);
    busWrite(13'h000, 32'h0000_1081);
    @(negedge clk);
    check("R6 other cause masked", {31'b0, irq}, 32'h0);
    busWrite(13'h000, 32'h0000_1082);
    busWrite(13'h004, 32'h0);
    @(negedge clk);
    check("R6 irq cleared", {31'b0, irq}, 32'h0);
    busWrite(13'h000, 32'h0);
  endtask

  task automatic testUserView();
    busWrite(13'h1008, 32'h5555_5555);
    busWrite(13'h100C, 32'h6666_6666);
    expectReg("R9 lower kept", 13'h008, 32'h0000_1000);
    expectReg("R9 upper kept", 13'h100C, 32'h0000_1FFF);
    busWrite(13'h1010, 32'h0000_0077);
    expectReg("R9 mask via user", 13'h010, 32'h0000_0077);
  endtask

  task automatic testMisalign();
    busWrite(13'h012, 32'h1234_5678);
    expectReg("R11 mask unchanged", 13'h010, 32'h0000_0077);
    expectReg("R11 err bit4", 13'h004, 32'h10);
    busWrite(13'h004, 32'h0);
  endtask

  task automatic testUnmapped();
    busWrite(13'h020, 32'hFFFF_FFFF);
    expectReg("R12 unmapped reads zero", 13'h020, 32'h0);
    expectReg("R12 err bit3", 13'h004, 32'h08);
    busWrite(13'h004, 32'h0);
    busWrite(13'h028, 32'h0);
    expectReg("R12 id unchanged", 13'h028, 32'h0000_032A);
    expectReg("R12 no error on id write", 13'h004, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testDirect();
    testQueue();
    testBound();
    testIrq();
    testUserView();
    testMisalign();
    testUnmapped();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule